// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host read and write a bank of 256 eight-bit configuration registers over three wires: an active-low chip select, a serial clock and a serial data input. A fourth wire, serial data out, returns read data. The serial pins are oversampled by a faster system clock. They pass through a synchronizer, and the edges of the serial clock are detected in the system clock domain, so every register in the block runs on one clock.

A transaction is one frame of 24 bits, clocked in while chip select is low. Each field is sent least-significant bit first. The frame carries the register address, then a direction flag, then seven padding bits the block never looks at, then a data byte. A write lands in the register bank only once the whole frame has arrived. On a read, the addressed register comes back on serial data out during the data byte of the same frame. An active-low reset returns every register to a computed default value.

Top module: `serreg_slave`

## Requirements
- R1: While `rst_n` is low for at least a few system clocks, every register `i` takes the default value `(i*37 + 0x5A) mod 256`, and `sdo` is 0.
- R2: Frame bits are taken on the rising edge of `sclk` while `cs_n` is low. Bits 0 to 7 hold the address (bit 0 first). Bit 8 is the direction flag (1 = read, 0 = write). Bits 9 to 15 are padding. Bits 16 to 23 hold the data byte, least-significant bit first.
- R3: A write frame stores its data byte in the addressed register once the 24th bit has been sampled.
- R4: On a read frame, `sdo` presents register bit k during the low phase of `sclk` that comes before the rising edge of frame bit 16+k. `sdo` changes only after a falling edge of `sclk`, or when chip select goes high.
- R5: The seven padding bits have no effect on any transfer.
- R6: If `cs_n` rises before 24 bits have been received, the partial frame is dropped and no register changes.
- R7: Bits clocked in after the 24th bit of a frame are ignored.
- R8: While `cs_n` is high, the bit position is cleared, so the next frame is decoded from its first bit.
- R9: `sdo` is 0 while `cs_n` is high. It is also 0 throughout a write frame and during bits 0 to 15 of a read frame.
- R10: A read frame leaves the register it reads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset; restores register defaults |
| cs_n | input | 1 | Active-low chip select; high ends or aborts a frame |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host; 0 when idle |

## Verification
The bench first reads a stride of registers and compares them with the default formula. It then writes every register through its own frame, varying the padding bits, and reads every register back. A design that mixed up bit order, shifted the address by one, or let the padding bits reach the data would fail most of these comparisons. Frames cut short at 23 bits or at 1 bit must leave the target unchanged, which a design that commits bit by bit would break. A frame stretched to 30 bits must store only its first data byte, which a counter that wraps would break. A short frame is followed at once by a full frame, which catches a counter that is not cleared while chip select is high. A reset pulse after writes must bring the defaults back. `sdo` is sampled during write frames and between frames, which catches a pin left driven with the last read bit.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_DIR,
      PH_PAD,
      PH_DATA
   } phase_e;

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[0] <= RST_VAL;
               else        st[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[g] <= RST_VAL;
               else        st[g] <= st[g-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];

endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
   import serreg_pkg::*;
#(
   parameter int   ADDR_W   = 8,
   parameter int   DATA_W   = 8,
   parameter int   PAD_W    = 7,
   parameter logic SDO_IDLE = 1'b0,
   localparam int  FRAME_LEN = ADDR_W + 1 + PAD_W + DATA_W,
   localparam int  CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              sclk_fall
);

   localparam int DIR_POS = ADDR_W;
   localparam int DAT_POS = ADDR_W + 1 + PAD_W;
   localparam int LAST    = FRAME_LEN - 1;

   logic              sclk_d;
   logic              sclk_rise;
   logic              done;
   logic              rw_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rsh;
   phase_e            phase;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign rd_addr   = addr_q;

   always_comb begin
      if (bit_cnt < CNT_W'(DIR_POS))       phase = PH_ADDR;
      else if (bit_cnt == CNT_W'(DIR_POS)) phase = PH_DIR;
      else if (bit_cnt < CNT_W'(DAT_POS))  phase = PH_PAD;
      else                                 phase = PH_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         done    <= 1'b0;
         rw_q    <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rsh     <= '0;
         sdo     <= SDO_IDLE;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            done    <= 1'b0;
            sdo     <= SDO_IDLE;
         end else begin
            if (sclk_rise && !done) begin
               case (phase)
                  PH_ADDR: addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
                  PH_DIR:  rw_q   <= sdi_s;
                  PH_PAD:  ;
                  PH_DATA: data_q <= {sdi_s, data_q[DATA_W-1:1]};
                  default: ;
               endcase
               if (bit_cnt == CNT_W'(DAT_POS - 1)) rsh <= rd_data;
               if (bit_cnt == CNT_W'(LAST)) begin
                  done <= 1'b1;
                  if (!rw_q) begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= {sdi_s, data_q[DATA_W-1:1]};
                  end
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (sclk_fall && !done && rw_q && phase == PH_DATA) begin
               sdo <= rsh[0];
               rsh <= {1'b0, rsh[DATA_W-1:1]};
            end
         end
      end
   end

endmodule

// File: rtl/serreg_file.sv
module serreg_file #(
   parameter int  ADDR_W  = 8,
   parameter int  DATA_W  = 8,
   parameter int  DEF_MUL = 37,
   parameter int  DEF_ADD = 90,
   localparam int DEPTH   = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_reg
         localparam logic [DATA_W-1:0] DEF =
            DATA_W'((i * DEF_MUL + DEF_ADD) % (1 << DATA_W));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  mem[i] <= DEF;
            else if (wr_en && wr_addr == ADDR_W'(i))     mem[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave #(
   parameter int   ADDR_W      = 8,
   parameter int   DATA_W      = 8,
   parameter int   PAD_W       = 7,
   parameter int   SYNC_STAGES = 2,
   parameter logic SDO_IDLE    = 1'b0,
   parameter int   DEF_MUL     = 37,
   parameter int   DEF_ADD     = 90
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic sdo
);

   localparam int FRAME_LEN = ADDR_W + 1 + PAD_W + DATA_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("serreg_slave: ADDR_W must lie in 2..10");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("serreg_slave: DATA_W must be at least 2");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("serreg_slave: PAD_W must not be negative");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serreg_slave: SYNC_STAGES must be at least 2");
   end

   logic              cs_sync;
   logic              sclk_sync;
   logic              sdi_sync;
   logic              sclk_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   serreg_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_sync, sclk_sync, sdi_sync})
   );

   serreg_frame #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAD_W    (PAD_W),
      .SDO_IDLE (SDO_IDLE)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_sync),
      .sclk_s    (sclk_sync),
      .sdi_s     (sdi_sync),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .sdo       (sdo),
      .bit_cnt   (bit_cnt),
      .sclk_fall (sclk_fall)
   );

   serreg_file #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .DEF_MUL (DEF_MUL),
      .DEF_ADD (DEF_ADD)
   ) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/serreg_slave_chk.sv
module serreg_slave_chk #(
   parameter int   CNT_W    = 5,
   parameter int   LAST     = 23,
   parameter logic SDO_IDLE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_q,
   input logic             fall,
   input logic             wr_en,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             sdo
);

   // R9
   sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> sdo == SDO_IDLE);

   // R8
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> bit_cnt == '0);

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(LAST));

   // R3
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R6
   wr_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!cs_q));

   // R4
   sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_q && !fall) |=> $stable(sdo));

endmodule

bind serreg_slave serreg_slave_chk #(
   .CNT_W    (CNT_W),
   .LAST     (FRAME_LEN - 1),
   .SDO_IDLE (SDO_IDLE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_q    (cs_sync),
   .fall    (sclk_fall),
   .wr_en   (wr_en),
   .bit_cnt (bit_cnt),
   .sdo     (sdo)
);

// File: tb/serreg_slave_bench.sv
`timescale 1ns/1ps
module serreg_slave_bench;

   localparam int H = 4;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n  = 1'b1;
   logic sclk  = 1'b0;
   logic sdi   = 1'b0;
   logic sdo;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   serreg_slave u_serreg_slave (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sclk  (sclk),
      .sdi   (sdi),
      .sdo   (sdo)
   );

   function automatic logic [7:0] def_val(int i);
      return 8'((i * 37 + 90) % 256);
   endfunction

   function automatic logic [7:0] pat_val(int i);
      return 8'(((i * 29) + 7) % 256) ^ 8'hA5;
   endfunction

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [7:0] a, input bit rw, input logic [6:0] pad,
                        input logic [7:0] d, input int nbits,
                        output logic [7:0] rd, output bit idle_ok);
      rd      = '0;
      idle_ok = 1'b1;
      cs_n = 1'b1; sclk = 1'b0; wait_clk(2);
      sclk = 1'b1; wait_clk(2);
      sclk = 1'b0; wait_clk(2);
      cs_n = 1'b0; wait_clk(4);
      for (int i = 0; i < nbits; i++) begin
         bit b;
         if (i < 8)       b = a[i];
         else if (i == 8) b = rw;
         else if (i < 16) b = pad[i-9];
         else if (i < 24) b = d[i-16];
         else             b = i[0];
         sdi = b;
         wait_clk(H);
         if (rw && i >= 16 && i < 24) rd[i-16] = sdo;
         if ((!rw || i < 16) && sdo !== 1'b0) idle_ok = 1'b0;
         sclk = 1'b1;
         wait_clk(H);
         sclk = 1'b0;
      end
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic rd_reg(input logic [7:0] a, input logic [6:0] pad, output logic [7:0] v);
      bit ok;
      frame(a, 1'b1, pad, 8'h00, 24, v, ok);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input logic [6:0] pad,
                         input int nbits, output bit idle_ok);
      logic [7:0] dummy;
      frame(a, 1'b0, pad, d, nbits, dummy, idle_ok);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual %0h expected %0h", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] v2;
      bit ok;

      wait_clk(6);
      // R1 / R9: idle level out of reset
      check(sdo === 1'b0, "R1 sdo after reset", int'(sdo), 0);
      rst_n = 1'b1;
      wait_clk(4);

      // R1 / R2 / R4: defaults read back over the serial port
      for (int i = 0; i < 256; i += 3) begin
         rd_reg(8'(i), 7'h00, v);
         check(v === def_val(i), "R1 default readback", int'(v), int'(def_val(i)));
      end

      // R3 / R5 / R9: write every register with varying padding
      for (int i = 0; i < 256; i++) begin
         wr_reg(8'(i), pat_val(i), 7'(i * 5), 24, ok);
         check(ok, "R9 sdo idle in write frame", 0, 1);
      end
      // R2 / R3 / R4: read every register back
      for (int i = 0; i < 256; i++) begin
         rd_reg(8'(i), 7'(~i), v);
         check(v === pat_val(i), "R3 written value", int'(v), int'(pat_val(i)));
      end

      // R10: reading twice returns the same value
      rd_reg(8'd5, 7'h00, v);
      rd_reg(8'd5, 7'h7F, v2);
      check(v2 === pat_val(5), "R10 read unchanged", int'(v2), int'(pat_val(5)));
      // R5: padding all ones on a read
      check(v === v2, "R5 padding on read", int'(v2), int'(v));

      // R6: 23-bit frame is discarded
      wr_reg(8'd10, ~pat_val(10), 7'h00, 23, ok);
      rd_reg(8'd10, 7'h00, v);
      check(v === pat_val(10), "R6 23-bit abort", int'(v), int'(pat_val(10)));
      // R6: single-bit frame is discarded
      wr_reg(8'd11, 8'h00, 7'h00, 1, ok);
      rd_reg(8'd11, 7'h00, v);
      check(v === pat_val(11), "R6 1-bit abort", int'(v), int'(pat_val(11)));

      // R8: partial frame then a full frame decodes from bit 0
      wr_reg(8'hFF, 8'h00, 7'h00, 13, ok);
      wr_reg(8'd20, 8'h3C, 7'h15, 24, ok);
      rd_reg(8'd20, 7'h00, v);
      check(v === 8'h3C, "R8 counter cleared", int'(v), 8'h3C);
      rd_reg(8'hFF, 7'h00, v);
      check(v === pat_val(255), "R8 partial target intact", int'(v), int'(pat_val(255)));

      // R7: extra bits after the 24th are ignored
      wr_reg(8'd30, 8'h96, 7'h00, 30, ok);
      rd_reg(8'd30, 7'h00, v);
      check(v === 8'h96, "R7 overlong frame", int'(v), 8'h96);

      // R9: sdo idle with cs high after a read ending in a 1 bit
      wr_reg(8'd40, 8'hFF, 7'h00, 24, ok);
      rd_reg(8'd40, 7'h00, v);
      check(v === 8'hFF, "R4 all-ones read", int'(v), 8'hFF);
      wait_clk(3);
      check(sdo === 1'b0, "R9 sdo idle cs high", int'(sdo), 0);

      // R1: reset restores defaults after writes
      rst_n = 1'b0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(4);
      rd_reg(8'd0, 7'h00, v);
      check(v === def_val(0), "R1 reset reg 0", int'(v), int'(def_val(0)));
      rd_reg(8'd40, 7'h00, v);
      check(v === def_val(40), "R1 reset reg 40", int'(v), int'(def_val(40)));
      rd_reg(8'd255, 7'h00, v);
      check(v === def_val(255), "R1 reset reg 255", int'(v), int'(def_val(255)));

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule